// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-interface master that runs one serial transaction at a time to an external PHY. It supports both the short (Clause 22) and the extended (Clause 45) frame formats. A host configures it through two registers behind a simple write port. The first is a 32-bit access word holding the PHY address, a register or device index, the framing select, a command and a start/busy flag. The second is a 16-bit data word. Each port write selects one register and is applied in a single clock.

Writing the access word with bit 0 set starts a frame of 64 MDC periods. The frame is a 32-bit preamble of ones followed by 32 header-and-data bits. MDC is derived from the system clock, and one of five rates is picked per transaction. The block changes MDIO while MDC is low. On read frames it releases MDIO from the turnaround onward and shifts in 16 bits on rising MDC edges. The captured word lands in the data register. An extended-register access takes two frames: an address frame, then a data frame. Software polls bit 0 between them.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read as zero, MDC is low and the MDIO output enable is low.
- R2: Every frame begins with 32 MDC periods in which MDIO is driven (enable high) to 1.
- R3: With access bit 3 clear, a frame sends start 01, then opcode 01 if access bit 1 is set (write) or 10 if it is clear (read). Next come the PHY address from access bits 15:11 and the register index from bits 10:6, MSB first. On a write, turnaround 10 and the 16 data-register bits follow, MSB first. MDIO changes only while MDC is low.
- R4: On read frames the output enable is low for the 2 turnaround bits and the 16 data bits. It stays high throughout write and address frames.
- R5: With access bit 3 set, the frame sends start 00, then an opcode chosen by access bits 2:1. The mapping is 00→00 (address), 01→01 (write), 10→11 (read) and 11→10 (read with post-increment). The PHY address follows, then the device address from bits 10:6.
- R6: In extended mode, address and write frames send turnaround 10 followed by the data register contents.
- R7: Access bit 0 reads 1 from the clock after a starting write until the last MDC period ends. It then reads 0, MDC rests low and MDIO is released.
- R8: While bit 0 reads 1, writes to either register are ignored. Readback and the frame in progress are unchanged.
- R9: Access bits 18:16 set the MDC half-period at the default 50 MHz system clock. The values are 0→10 clocks (2.5 MHz), 1→5, 2→2, 3→1, 4→20 (1.25 MHz), and 5–7 behave as 4.
- R10: When a read frame ends, the 16 sampled bits appear in the data register, first-received bit as bit 15.
- R11: An idle write of the access word with bit 0 clear stores the fields without starting a frame. The fields read back as bits 18:16, 15:11, 10:6, 3 and 2:1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the access word, 1 the data word |
| reg_wdata | input | 32 | Write data (data word uses bits 15:0) |
| acc_rdata | output | 32 | Access word readback, bit 0 is busy |
| data_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A wrong bit counter or header latch shows at the pins within one frame. The 64-bit capture of driven bits then differs from the expected preamble and header, or the enable drops at the wrong position. The same window reveals a wrong divider setting, as a wrong high-time on the first MDC pulse. An error in the busy or capture path surfaces at the register port at the end of that same frame. The busy bit then clears early or late, a blocked write leaks into readback, or the data register returns a shifted word.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // frame geometry fixed by the management protocol
   localparam int PRE_BITS   = 32;
   localparam int FRAME_BITS = 64;
   localparam int TA_POS     = 46;
   localparam int DATA_POS   = 48;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   typedef enum logic [1:0] {
      CMD_ADDR     = 2'b00,
      CMD_WRITE    = 2'b01,
      CMD_READ     = 2'b10,
      CMD_READ_INC = 2'b11
   } ext_cmd_e;

   function automatic logic [1:0] ext_opcode(ext_cmd_e c);
      case (c)
         CMD_ADDR:  return 2'b00;
         CMD_WRITE: return 2'b01;
         CMD_READ:  return 2'b11;
         default:   return 2'b10;
      endcase
   endfunction

   // MDC half period in system clocks for a rate select code
   function automatic int half_period(int sys_khz, logic [2:0] sel);
      int rate_khz;
      case (sel)
         3'd0:    rate_khz = 2500;
         3'd1:    rate_khz = 5000;
         3'd2:    rate_khz = 12500;
         3'd3:    rate_khz = 25000;
         default: rate_khz = 1250;
      endcase
      return sys_khz / (2 * rate_khz);
   endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int SYS_KHZ = 50000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] rate_sel,
   output logic       tick
);
   localparam int MAX_HALF = SYS_KHZ / 2500;
   localparam int CNT_W    = $clog2(MAX_HALF + 1);

   generate
      if (SYS_KHZ % 50000 != 0) begin : g_bad_clk
         $error("mdio_clkdiv: SYS_KHZ must be a multiple of 50000");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;

   always_comb begin
      half_m1 = CNT_W'(mdio_pkg::half_period(SYS_KHZ, rate_sel) - 1);
      tick    = run && (cnt_q == half_m1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   // R9
   div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= half_m1));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
   parameter int SYNC_STAGES = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        tick,
   input  logic [31:0] hdr,
   input  logic        rd_op,
   input  logic        mdio_i,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        busy,
   output logic        rd_done,
   output logic [15:0] rd_word
);
   import mdio_pkg::*;

   logic din;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 2) begin : g_bad_sync
         $error("mdio_frame: SYNC_STAGES must be 0..2");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign din = mdio_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '1;
            else begin
               sr_q[0] <= mdio_i;
               for (int k = 1; k < SYNC_STAGES; k++) sr_q[k] <= sr_q[k-1];
            end
         end
         assign din = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   logic             busy_q, mdc_q, rd_q, done_q;
   logic [IDX_W-1:0] idx_q;
   logic [31:0]      hdr_q;
   logic [15:0]      rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mdc_q  <= 1'b0;
         rd_q   <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         hdr_q  <= '0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               mdc_q  <= 1'b0;
               idx_q  <= '0;
               hdr_q  <= hdr;
               rd_q   <= rd_op;
            end
         end else if (tick) begin
            if (!mdc_q) begin
               mdc_q <= 1'b1;
               if (idx_q >= IDX_W'(DATA_POS)) rx_q <= {rx_q[14:0], din};
            end else begin
               mdc_q <= 1'b0;
               if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                  busy_q <= 1'b0;
                  done_q <= rd_q;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   end

   // preamble bits are ones; afterwards index the latched header MSB first
   always_comb begin
      if (idx_q < IDX_W'(PRE_BITS)) mdio_o = 1'b1;
      else                          mdio_o = hdr_q[~idx_q[4:0]];
      mdio_oe = busy_q && !(rd_q && idx_q >= IDX_W'(TA_POS));
   end

   assign mdc     = mdc_q;
   assign busy    = busy_q;
   assign rd_done = done_q;
   assign rd_word = rx_q;

   // R3
   setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mdc_q) |-> $stable(mdio_o));
   // R4
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !mdio_oe) |-> rd_q);
   // R7
   end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(idx_q) == IDX_W'(FRAME_BITS - 1) && $past(mdc_q)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int SYS_KHZ     = 50000,
   parameter int SYNC_STAGES = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] acc_rdata,
   output logic [15:0] data_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   import mdio_pkg::*;

   logic [2:0]  rate_q;
   logic [4:0]  phy_q, sel_q;
   logic        ext_q;
   logic [1:0]  cmd_q;
   logic [15:0] data_q;

   logic        busy, rd_done, tick, start;
   logic [15:0] rd_word;
   logic [31:0] hdr_w;
   logic        rd_w, ext_w;
   logic [1:0]  st_w, op_w;
   logic        unused_bits;

   assign unused_bits = ^{reg_wdata[31:19], reg_wdata[5:4]};

   assign ext_w = reg_wdata[3];
   assign start = reg_wr && !reg_sel && !busy && reg_wdata[0];

   always_comb begin
      rd_w = ext_w ? reg_wdata[2] : !reg_wdata[1];
      st_w = ext_w ? 2'b00 : 2'b01;
      if (ext_w) op_w = ext_opcode(ext_cmd_e'(reg_wdata[2:1]));
      else       op_w = reg_wdata[1] ? 2'b01 : 2'b10;
      hdr_w = {st_w, op_w, reg_wdata[15:11], reg_wdata[10:6], 2'b10,
               rd_w ? 16'hFFFF : data_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         phy_q  <= '0;
         sel_q  <= '0;
         ext_q  <= 1'b0;
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         if (reg_wr && !busy) begin
            if (!reg_sel) begin
               rate_q <= reg_wdata[18:16];
               phy_q  <= reg_wdata[15:11];
               sel_q  <= reg_wdata[10:6];
               ext_q  <= reg_wdata[3];
               cmd_q  <= reg_wdata[2:1];
            end else begin
               data_q <= reg_wdata[15:0];
            end
         end
         if (rd_done) data_q <= rd_word;
      end
   end

   mdio_clkdiv #(.SYS_KHZ(SYS_KHZ)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .rate_sel (rate_q),
      .tick     (tick)
   );

   mdio_frame #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tick    (tick),
      .hdr     (hdr_w),
      .rd_op   (rd_w),
      .mdio_i  (mdio_i),
      .mdc     (mdc),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .busy    (busy),
      .rd_done (rd_done),
      .rd_word (rd_word)
   );

   assign acc_rdata  = {13'd0, rate_q, phy_q, sel_q, 2'b00, ext_q, cmd_q, busy};
   assign data_rdata = data_q;

   // R8
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && !reg_sel) |=> $stable(acc_rdata[18:1]));
   // R7
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));
   // R10
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_done) |=> $stable(data_q));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] acc_rdata;
   logic [15:0] data_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 0;

   logic [63:0] cap_o, cap_oe;
   int          mon_idx = 0;
   logic [15:0] resp = '0;

   always #10 clk = ~clk;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .acc_rdata(acc_rdata), .data_rdata(data_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY-side model: record pins at rising MDC, present read data after falling MDC
   always @(posedge mdc) begin
      if (mon_idx < 64) begin
         cap_o[mon_idx]  = mdio_o;
         cap_oe[mon_idx] = mdio_oe;
      end
      mon_idx = mon_idx + 1;
   end

   always @(negedge mdc) begin
      if (mon_idx >= 48 && mon_idx < 64) mdio_i = resp[63 - mon_idx];
      else                               mdio_i = 1'b1;
   end

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic reg_write(bit sel, logic [31:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int k;
      k = 0;
      while (acc_rdata[0] === 1'b1 && k < 20000) begin
         @(negedge clk);
         k++;
      end
      if (k >= 20000) chk("R7 busy timeout", 64'd1, 64'd0);
   endtask

   function automatic logic [31:0] acc_word(logic [2:0] rate, logic [4:0] pa,
         logic [4:0] ra, bit ext, logic [1:0] cmd, bit go);
      return {13'd0, rate, pa, ra, 2'b00, ext, cmd, go};
   endfunction

   // expected 32 post-preamble bits; opcode table per R3 / R5
   function automatic logic [31:0] exp_hdr(bit ext, logic [1:0] cmd,
         logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
      logic [1:0] st, op;
      if (ext) begin
         st = 2'b00;
         case (cmd)
            2'b00: op = 2'b00;
            2'b01: op = 2'b01;
            2'b10: op = 2'b11;
            default: op = 2'b10;
         endcase
      end else begin
         st = 2'b01;
         op = cmd[0] ? 2'b01 : 2'b10;
      end
      return {st, op, pa, ra, 2'b10, d};
   endfunction

   task automatic run_frame(logic [2:0] rate, bit ext, logic [1:0] cmd,
         logic [4:0] pa, logic [4:0] ra, logic [15:0] rsp);
      resp = rsp;
      mon_idx = 0;
      reg_write(1'b0, acc_word(rate, pa, ra, ext, cmd, 1'b1));
      wait_idle();
   endtask

   task automatic check_frame(string tag, logic [31:0] exp, bit rd);
      logic [31:0] got_o, got_oe;
      for (int k = 0; k < 32; k++) begin
         got_o[31-k]  = cap_o[32+k];
         got_oe[31-k] = cap_oe[32+k];
      end
      chk({"R2 preamble ", tag}, {cap_oe[31:0], cap_o[31:0]}, {64{1'b1}});
      if (rd) begin
         chk({"R4 release ", tag}, {50'd0, got_oe}, {50'd0, 14'h3FFF, 18'd0});
         chk({tag, " header"}, {50'd0, got_o[31:18]}, {50'd0, exp[31:18]});
      end else begin
         chk({"R4 driven ", tag}, {32'd0, got_oe}, {32'd0, 32'hFFFF_FFFF});
         chk({tag, " header"}, {32'd0, got_o}, {32'd0, exp});
      end
      chk({"R7 end ", tag}, {61'd0, acc_rdata[0], mdc, mdio_oe}, 64'd0);
   endtask

   task automatic t_reset();
      // R1
      chk("R1 acc", {32'd0, acc_rdata}, 64'd0);
      chk("R1 data", {48'd0, data_rdata}, 64'd0);
      chk("R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);
   endtask

   task automatic t_fields();
      // R11: fields stored, no frame started
      reg_write(1'b0, 32'hFFFF_FFFE);
      chk("R11 readback", {32'd0, acc_rdata}, {32'd0, 32'h0007_FFCE});
      repeat (60) @(negedge clk);
      chk("R11 no frame", {62'd0, mdc, mdio_oe}, 64'd0);
   endtask

   task automatic t_short_write();
      reg_write(1'b1, 32'h0000_A5C3);
      resp = '0;
      mon_idx = 0;
      reg_write(1'b0, acc_word(3'd3, 5'h11, 5'h0A, 1'b0, 2'b01, 1'b1));
      // R7 busy reads 1 while running; R11 fields visible
      chk("R7 busy set", {63'd0, acc_rdata[0]}, 64'd1);
      chk("R11 fields during frame", {32'd0, acc_rdata},
          {32'd0, acc_word(3'd3, 5'h11, 5'h0A, 1'b0, 2'b01, 1'b1)});
      wait_idle();
      // R3
      check_frame("R3 short write", exp_hdr(1'b0, 2'b01, 5'h11, 5'h0A, 16'hA5C3), 1'b0);
   endtask

   task automatic t_short_read();
      run_frame(3'd2, 1'b0, 2'b00, 5'h05, 5'h1F, 16'hBEEF);
      check_frame("R3 short read", exp_hdr(1'b0, 2'b00, 5'h05, 5'h1F, 16'h0), 1'b1);
      repeat (2) @(negedge clk);
      // R10
      chk("R10 read data", {48'd0, data_rdata}, {48'd0, 16'hBEEF});
   endtask

   task automatic t_ext_ops();
      // R5 / R6 address frame
      reg_write(1'b1, 32'h0000_1234);
      run_frame(3'd3, 1'b1, 2'b00, 5'h03, 5'h1E, 16'h0);
      check_frame("R6 ext addr", exp_hdr(1'b1, 2'b00, 5'h03, 5'h1E, 16'h1234), 1'b0);
      // R6 write frame
      reg_write(1'b1, 32'h0000_CAFE);
      run_frame(3'd3, 1'b1, 2'b01, 5'h03, 5'h1E, 16'h0);
      check_frame("R6 ext write", exp_hdr(1'b1, 2'b01, 5'h03, 5'h1E, 16'hCAFE), 1'b0);
      // R5 read
      run_frame(3'd1, 1'b1, 2'b10, 5'h1C, 5'h01, 16'h8001);
      check_frame("R5 ext read", exp_hdr(1'b1, 2'b10, 5'h1C, 5'h01, 16'h0), 1'b1);
      repeat (2) @(negedge clk);
      chk("R10 ext read data", {48'd0, data_rdata}, {48'd0, 16'h8001});
      // R5 read with post-increment
      run_frame(3'd3, 1'b1, 2'b11, 5'h1C, 5'h01, 16'h7FFE);
      check_frame("R5 ext read-inc", exp_hdr(1'b1, 2'b11, 5'h1C, 5'h01, 16'h0), 1'b1);
      repeat (2) @(negedge clk);
      chk("R10 read-inc data", {48'd0, data_rdata}, {48'd0, 16'h7FFE});
   endtask

   task automatic t_busy_ignore();
      logic [31:0] a0;
      reg_write(1'b1, 32'h0000_1111);
      resp = '0;
      mon_idx = 0;
      a0 = acc_word(3'd4, 5'h01, 5'h02, 1'b0, 2'b01, 1'b1);
      reg_write(1'b0, a0);
      repeat (200) @(negedge clk);
      reg_write(1'b0, acc_word(3'd0, 5'h1F, 5'h15, 1'b1, 2'b10, 1'b1));
      reg_write(1'b1, 32'h0000_2222);
      // R8
      chk("R8 acc unchanged", {32'd0, acc_rdata}, {32'd0, a0});
      chk("R8 data unchanged", {48'd0, data_rdata}, {48'd0, 16'h1111});
      wait_idle();
      check_frame("R8 frame intact", exp_hdr(1'b0, 2'b01, 5'h01, 5'h02, 16'h1111), 1'b0);
   endtask

   task automatic t_rates();
      int exp_half [6] = '{10, 5, 2, 1, 20, 20};
      for (int s = 0; s < 6; s++) begin
         realtime t0;
         int w;
         resp = '0;
         mon_idx = 0;
         reg_write(1'b0, acc_word(3'(s), 5'h02, 5'h03, 1'b0, 2'b00, 1'b1));
         @(posedge mdc);
         t0 = $realtime;
         @(negedge mdc);
         w = int'(($realtime - t0) / 20.0);
         // R9
         chk("R9 mdc half period", 64'(w), 64'(exp_half[s]));
         wait_idle();
      end
   endtask

   initial begin
      #(20ns * 150000);
      if (!done_flag) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_short_write();
      t_short_read();
      t_ext_ops();
      t_busy_ignore();
      t_rates();
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule